// File: doc/BRIEF.md
# Sensorless Three-Phase Motor Spin-Up Sequencer

This block takes a three-phase brushless motor from standstill to closed-loop running without rotor position sensors. When `enable` rises, the sequencer goes through three modes in a fixed order. First it holds one commutation state so that the rotor settles against a known phase pair. Next it steps the six-step commutation counter open-loop at a rate that increases linearly. Last it hands the step clock over to an external clock, which comes from the back-EMF phase-locked loop that lies outside this block.

The align time and the ramp time are separate programmable cycle counts. The ramp starts with a step period of `period_init`. After each step the period shrinks by `period_dec`, and it never goes below `period_floor`. A `tach` output toggles once for every commutation advance, so once the loop is locked its frequency follows motor speed. Dropping `enable` returns the block to idle with the drivers off.

Top module: `bldc_spinup_seq`

## Requirements
- R1: During reset and after reset the outputs are `seq_mode`=00 (idle), `comm_state`=0, `tach`=0 and `drive_on`=0.
- R2: The mode codes are 00 idle, 01 align, 10 ramp and 11 run. The block leaves idle for align in the cycle after it samples `enable` high. The order is always idle, align, ramp, run, and the block stays in run.
- R3: Align lasts exactly max(`align_cycles`,1) cycles, and `comm_state` stays at 0 throughout.
- R4: Ramp lasts exactly max(`ramp_cycles`,1) cycles, and run follows.
- R5: In ramp the k-th step (k from 0) comes max(`period_init` − k·`period_dec`, `period_floor`, 1) cycles after the previous step, or after ramp entry for k=0. This assumes `period_floor` ≤ `period_init`. A step that falls in the last ramp cycle still takes effect.
- R6: With `step_dir`=1 each advance moves `comm_state` 0→1→…→5→0. With `step_dir`=0 each advance moves it 0→5→4→…→1→0. No other values appear.
- R7: In run, each rising edge of `run_clk` advances `comm_state` by exactly one step. The result is visible within three clock cycles after `run_clk` rises. Edges of `run_clk` in align or ramp have no effect.
- R8: `tach` inverts on every advance of `comm_state` and on no other cycle. It returns to 0 in idle.
- R9: When `enable` is sampled low, the next cycle shows idle with `comm_state`=0, `tach`=0 and `drive_on`=0. A `run_clk` edge that is detected in the same cycle is discarded.
- R10: `drive_on` is 1 in align, ramp and run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Start request; low forces idle |
| step_dir | input | 1 | 1 = count up, 0 = count down |
| align_cycles | input | CNT_W | Align duration in cycles |
| ramp_cycles | input | CNT_W | Ramp duration in cycles |
| period_init | input | PER_W | First ramp step period in cycles |
| period_floor | input | PER_W | Shortest ramp step period |
| period_dec | input | PER_W | Period decrement per ramp step |
| run_clk | input | 1 | Asynchronous step clock from the locked loop |
| comm_state | output | 3 | Six-step commutation state 0..5 |
| tach | output | 1 | Toggles on every commutation advance |
| seq_mode | output | 2 | Current mode code |
| drive_on | output | 1 | Phase drivers enabled |

## Verification
Two pairs of events can fall in the same cycle. A ramp step can land on the last ramp cycle, at the moment the mode moves to run. A detected `run_clk` edge can arrive in the cycle where `enable` is sampled low. For the first pair, a directed trial uses a constant period that divides the ramp length, and the bench checks that the final step's count and `tach` parity show up in the first run cycle. For the second pair, the bench raises `run_clk` two cycles before it drops `enable`, timed so the synchronised edge meets the disable, and it expects idle with state 0 and `tach` 0 in the next cycle. Random trials mix durations, periods and decrements so that clamps and coincidences also occur unplanned.

// File: rtl/bldc_seq_pkg.sv
package bldc_seq_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE  = 2'd0,
      MODE_ALIGN = 2'd1,
      MODE_RAMP  = 2'd2,
      MODE_RUN   = 2'd3
   } seq_mode_e;

   localparam int unsigned NUM_STEPS = 6;
   localparam int unsigned STATE_W   = 3;

endpackage

// File: rtl/seq_mode_fsm.sv
module seq_mode_fsm
   import bldc_seq_pkg::*;
#(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] align_cycles,
   input  logic [CNT_W-1:0] ramp_cycles,
   output seq_mode_e        mode
);

   localparam logic [CNT_W-1:0] TMR_ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("seq_mode_fsm: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MODE_IDLE;
         tmr  <= TMR_ONE;
      end else if (!enable) begin
         mode <= MODE_IDLE;
         tmr  <= TMR_ONE;
      end else begin
         case (mode)
            MODE_IDLE: begin
               mode <= MODE_ALIGN;
               tmr  <= TMR_ONE;
            end
            MODE_ALIGN: begin
               if (tmr >= align_cycles) begin
                  mode <= MODE_RAMP;
                  tmr  <= TMR_ONE;
               end else begin
                  tmr <= tmr + TMR_ONE;
               end
            end
            MODE_RAMP: begin
               if (tmr >= ramp_cycles) begin
                  mode <= MODE_RUN;
                  tmr  <= TMR_ONE;
               end else begin
                  tmr <= tmr + TMR_ONE;
               end
            end
            default: begin
               mode <= MODE_RUN;
            end
         endcase
      end
   end

endmodule

// File: rtl/seq_ramp_gen.sv
module seq_ramp_gen #(
   parameter int unsigned PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [PER_W-1:0] period_init,
   input  logic [PER_W-1:0] period_floor,
   input  logic [PER_W-1:0] period_dec,
   output logic             step
);

   localparam logic [PER_W-1:0] CNT_ONE = PER_W'(1);

   if (PER_W < 2) begin : g_bad_per_w
      $error("seq_ramp_gen: PER_W must be at least 2");
   end

   logic [PER_W-1:0] cur_per;
   logic [PER_W-1:0] elapsed;
   logic [PER_W:0]   floor_plus_dec;
   logic [PER_W-1:0] next_per;

   // Saturating decrement: a single compare against floor+dec avoids underflow
   always_comb begin
      floor_plus_dec = {1'b0, period_floor} + {1'b0, period_dec};
      if ({1'b0, cur_per} > floor_plus_dec) begin
         next_per = cur_per - period_dec;
      end else begin
         next_per = period_floor;
      end
   end

   assign step = active && (elapsed >= cur_per);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_per <= '0;
         elapsed <= CNT_ONE;
      end else if (!active) begin
         cur_per <= period_init;
         elapsed <= CNT_ONE;
      end else if (step) begin
         cur_per <= next_per;
         elapsed <= CNT_ONE;
      end else begin
         elapsed <= elapsed + CNT_ONE;
      end
   end

endmodule

// File: rtl/seq_edge_sync.sv
module seq_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("seq_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain[0] <= 1'b0;
      end else begin
         chain[0] <= async_in;
      end
   end

   for (genvar i = 1; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[i] <= 1'b0;
         end else begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/seq_comm_ctr.sv
module seq_comm_ctr #(
   parameter int unsigned NUM     = 6,
   parameter int unsigned STATE_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               advance,
   input  logic               up,
   output logic [STATE_W-1:0] state,
   output logic               tach
);

   localparam logic [STATE_W-1:0] LAST = STATE_W'(NUM - 1);
   localparam logic [STATE_W-1:0] ONE  = STATE_W'(1);

   if (NUM < 2 || NUM > (1 << STATE_W)) begin : g_bad_num
      $error("seq_comm_ctr: NUM does not fit STATE_W");
   end

   logic [STATE_W-1:0] nxt_up;
   logic [STATE_W-1:0] nxt_dn;

   always_comb begin
      nxt_up = (state == LAST) ? '0 : state + ONE;
      nxt_dn = (state == '0) ? LAST : state - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= '0;
         tach  <= 1'b0;
      end else if (clear) begin
         state <= '0;
         tach  <= 1'b0;
      end else if (advance) begin
         state <= up ? nxt_up : nxt_dn;
         tach  <= ~tach;
      end
   end

endmodule

// File: rtl/bldc_spinup_seq.sv
module bldc_spinup_seq
   import bldc_seq_pkg::*;
#(
   parameter int unsigned CNT_W       = 24,
   parameter int unsigned PER_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               step_dir,
   input  logic [CNT_W-1:0]   align_cycles,
   input  logic [CNT_W-1:0]   ramp_cycles,
   input  logic [PER_W-1:0]   period_init,
   input  logic [PER_W-1:0]   period_floor,
   input  logic [PER_W-1:0]   period_dec,
   input  logic               run_clk,
   output logic [STATE_W-1:0] comm_state,
   output logic               tach,
   output logic [1:0]         seq_mode,
   output logic               drive_on
);

   seq_mode_e mode;
   logic      ramp_step;
   logic      run_rise;
   logic      advance;
   logic      clear;

   seq_mode_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .align_cycles (align_cycles),
      .ramp_cycles  (ramp_cycles),
      .mode         (mode)
   );

   seq_ramp_gen #(.PER_W(PER_W)) u_ramp (
      .clk          (clk),
      .rst_n        (rst_n),
      .active       (mode == MODE_RAMP),
      .period_init  (period_init),
      .period_floor (period_floor),
      .period_dec   (period_dec),
      .step         (ramp_step)
   );

   seq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (run_clk),
      .rise     (run_rise)
   );

   // Disable has priority: it clears state even when an advance is pending
   assign clear   = !enable || (mode == MODE_IDLE);
   assign advance = enable && (ramp_step || ((mode == MODE_RUN) && run_rise));

   seq_comm_ctr #(.NUM(NUM_STEPS), .STATE_W(STATE_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .advance (advance),
      .up      (step_dir),
      .state   (comm_state),
      .tach    (tach)
   );

   assign seq_mode = mode;
   assign drive_on = (mode != MODE_IDLE);

endmodule

// File: rtl/bldc_spinup_seq_chk.sv
module bldc_spinup_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic       step_dir,
   input logic [2:0] comm_state,
   input logic       tach,
   input logic [1:0] seq_mode
);

   a_r2_run_after_ramp: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_mode == 2'd3) |-> ($past(seq_mode) == 2'd2 || $past(seq_mode) == 2'd3));

   a_r2_ramp_after_align: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_mode == 2'd2) |-> ($past(seq_mode) == 2'd1 || $past(seq_mode) == 2'd2));

   a_r3_align_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_mode == 2'd1) |-> (comm_state == 3'd0));

   a_r6_state_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      comm_state <= 3'd5);

   a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_mode != 2'd0 && $past(seq_mode) != 2'd0 && comm_state != $past(comm_state))
      |-> ($past(step_dir) ?
             (comm_state == (($past(comm_state) == 3'd5) ? 3'd0 : $past(comm_state) + 3'd1)) :
             (comm_state == (($past(comm_state) == 3'd0) ? 3'd5 : $past(comm_state) - 3'd1))));

   a_r8_tach_tracks_step: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_mode != 2'd0 && $past(seq_mode) != 2'd0)
      |-> ((tach != $past(tach)) == (comm_state != $past(comm_state))));

   a_r9_disable_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (seq_mode == 2'd0 && comm_state == 3'd0 && !tach));

endmodule

bind bldc_spinup_seq bldc_spinup_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .step_dir   (step_dir),
   .comm_state (comm_state),
   .tach       (tach),
   .seq_mode   (seq_mode)
);

// File: tb/bldc_spinup_seq_bench.sv
`timescale 1ns/1ps
module bldc_spinup_seq_bench;

   localparam int CNT_W = 24;
   localparam int PER_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic             step_dir = 1'b1;
   logic             run_clk = 1'b0;
   logic [CNT_W-1:0] align_cycles = '0;
   logic [CNT_W-1:0] ramp_cycles = '0;
   logic [PER_W-1:0] period_init = '0;
   logic [PER_W-1:0] period_floor = '0;
   logic [PER_W-1:0] period_dec = '0;
   logic [2:0]       comm_state;
   logic             tach;
   logic [1:0]       seq_mode;
   logic             drive_on;

   int  n_checks = 0;
   int  n_fail = 0;
   int  cur_state = 0;
   int  cur_tach = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   bldc_spinup_seq u_bldc_spinup_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .step_dir     (step_dir),
      .align_cycles (align_cycles),
      .ramp_cycles  (ramp_cycles),
      .period_init  (period_init),
      .period_floor (period_floor),
      .period_dec   (period_dec),
      .run_clk      (run_clk),
      .comm_state   (comm_state),
      .tach         (tach),
      .seq_mode     (seq_mode),
      .drive_on     (drive_on)
   );

   task automatic check_eq(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Steps land at cumulative sums of the clamped period sequence
   function automatic int exp_steps(int p0, int dec, int pfl, int rl);
      int t = 0;
      int n = 0;
      int lim = (rl < 1) ? 1 : rl;
      for (int k = 0; k <= lim; k++) begin
         int pk = p0 - k * dec;
         if (pk < pfl) pk = pfl;
         if (pk < 1) pk = 1;
         t += pk;
         if (t > lim) break;
         n++;
      end
      return n;
   endfunction

   function automatic int wrap_state(int n, bit up);
      return up ? (n % 6) : ((6 - (n % 6)) % 6);
   endfunction

   task automatic run_trial(int a, int r, int p0, int dec, int pfl, bit up, bit noise);
      int acnt = 0;
      int rcnt = 0;
      int chg = 0;
      int bad = 0;
      int first = -1;
      int prev = 0;
      int guard = 0;
      int n;
      @(negedge clk);
      align_cycles = CNT_W'(a);
      ramp_cycles  = CNT_W'(r);
      period_init  = PER_W'(p0);
      period_dec   = PER_W'(dec);
      period_floor = PER_W'(pfl);
      step_dir     = up;
      enable       = 1'b1;
      while (guard < a + r + 20) begin
         @(negedge clk);
         guard++;
         if (first < 0) first = seq_mode;
         if (seq_mode == 2'd1) begin
            acnt++;
            if (comm_state != 3'd0) bad++;
            if (noise) run_clk = ((acnt / 2) % 2) == 1;
         end else if (seq_mode == 2'd2) begin
            run_clk = 1'b0;
            rcnt++;
            if (int'(comm_state) != prev) chg++;
         end else begin
            break;
         end
         prev = comm_state;
      end
      if (int'(comm_state) != prev) chg++;
      n = exp_steps(p0, dec, pfl, r);
      check_eq("R2 first mode after enable", first, 1);
      check_eq("R2 mode after ramp", seq_mode, 3);
      check_eq("R3 align length", acnt, (a < 1) ? 1 : a);
      check_eq("R3/R7 state moved in align", bad, 0);
      check_eq("R4 ramp length", rcnt, (r < 1) ? 1 : r);
      check_eq("R5 ramp step count", chg, n);
      check_eq("R6 state after ramp", comm_state, wrap_state(n, up));
      check_eq("R8 tach parity after ramp", tach, n % 2);
      check_eq("R10 drive_on in run", drive_on, 1);
      cur_state = wrap_state(n, up);
      cur_tach  = n % 2;
   endtask

   task automatic run_pulses(int cnt);
      for (int i = 0; i < cnt; i++) begin
         run_clk = 1'b1;
         repeat (3) @(negedge clk);
         cur_state = step_dir ? ((cur_state + 1) % 6) : ((cur_state + 5) % 6);
         cur_tach  = 1 - cur_tach;
         check_eq("R7 run edge advance", comm_state, cur_state);
         check_eq("R8 tach on run edge", tach, cur_tach);
         run_clk = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic stop_check();
      enable = 1'b0;
      @(negedge clk);
      check_eq("R9 idle mode", seq_mode, 0);
      check_eq("R9 state cleared", comm_state, 0);
      check_eq("R9 tach cleared", tach, 0);
      check_eq("R9 drive_on off", drive_on, 0);
      @(negedge clk);
   endtask

   task automatic coincide_check();
      run_clk = 1'b1;
      repeat (2) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      check_eq("R9 edge with disable mode", seq_mode, 0);
      check_eq("R9 edge with disable state", comm_state, 0);
      check_eq("R9 edge with disable tach", tach, 0);
      run_clk = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R2 actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7041));
      repeat (3) @(negedge clk);
      check_eq("R1 reset mode", seq_mode, 0);
      check_eq("R1 reset state", comm_state, 0);
      check_eq("R1 reset tach", tach, 0);
      check_eq("R1 reset drive_on", drive_on, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_eq("R1 idle without enable", seq_mode, 0);

      // last ramp step lands on the final ramp cycle
      run_trial(5, 8, 4, 0, 4, 1'b1, 1'b0);
      run_pulses(7);
      stop_check();

      // decrementing period clamping at the floor, counting down
      run_trial(0, 50, 10, 3, 2, 1'b0, 1'b0);
      run_pulses(8);
      coincide_check();

      // run_clk activity during align must be ignored
      run_trial(30, 12, 3, 1, 1, 1'b1, 1'b1);
      run_pulses(2);
      stop_check();

      for (int t = 0; t < 10; t++) begin
         int pfl = $urandom_range(0, 8);
         int p0  = pfl + $urandom_range(0, 40);
         run_trial($urandom_range(0, 60), $urandom_range(1, 300), p0,
                   $urandom_range(0, 6), pfl, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
         run_pulses($urandom_range(1, 8));
         if (t % 3 == 0) coincide_check();
         else stop_check();
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule